// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages one general-purpose I/O port of `WIDTH` pins, eight by default, on a simple synchronous register bus. Software programs four registers: an output latch, a direction mask, a pull-up mask and a slew-limit mask. Each pin can also be taken over by a peripheral or an analog function, using per-pin enable inputs. For every pin the block works out the pad output value, the output enable, the pull-up enable and the slew control. It also forms the value returned when the latch register is read.

Ownership of each pin is settled by a fixed priority. Analog comes first, then the peripheral, then plain GPIO. Pad inputs pass through a synchronizer before they reach the read path.

Software can load the latch while a pin is still an input and then set the direction bit. The pin then drives the preloaded level without a glitch from stale data. The bus has a write strobe, a read strobe and a 2-bit register select. Read data is registered and changes only on a clock edge where the read strobe is high.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all four registers are 0. Every pad_oe, pad_pull and pad_slew bit is then 0, and pad_out is 0.
- R2: bus_addr selects the register: 0 is the output latch, 1 the direction mask, 2 the pull-up mask and 3 the slew mask. A write with bus_wr high stores bus_wdata. A read of address 1, 2 or 3 returns the stored value.
- R3: A GPIO-owned pin with direction bit 0 has pad_oe 0. A read of address 0 returns the level of pad_in for that bit, after it has passed SYNC_STAGES (default 2) flops.
- R4: Writing address 0 while a pin is an input changes neither pad_oe nor pad_out of that pin. Once the direction bit is later set to 1, the pin drives the value that was written.
- R5: A GPIO-owned pin with direction bit 1 has pad_oe 1 and pad_out equal to its latch bit. A read of address 0 returns the latch bit.
- R6: A pin with periph_en 1 and analog_en 0 takes pad_oe from periph_oe and pad_out from periph_out. Its bit in a read of address 0 still follows the direction bit: the latch when the bit is 1, the synchronized pad level when it is 0.
- R7: A pin with analog_en 1 has pad_oe, pad_out, pad_pull and pad_slew all 0, whatever periph_en and the registers hold. Its bit in a read of address 0 is 0.
- R8: pad_pull is 1 only when the pull-up mask bit is 1 and the pin is a digital input, meaning pad_oe is 0 and analog_en is 0.
- R9: pad_slew equals the slew mask bit for every pin whose analog_en is 0.
- R10: bus_rdata is loaded on a rising clock edge with bus_rd high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| periph_en | input | WIDTH | Peripheral takes the pin |
| periph_oe | input | WIDTH | Peripheral output enable |
| periph_out | input | WIDTH | Peripheral output value |
| analog_en | input | WIDTH | Analog function takes the pin |
| pad_in | input | WIDTH | Pad input level (asynchronous) |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |
| pad_pull | output | WIDTH | Pad pull-up enable |
| pad_slew | output | WIDTH | Pad slew-limit enable |

## Verification
The assertions assume that bus_addr is a known value whenever bus_wr or bus_rd is high. They also assume that the per-pin enable inputs are free of X during operation, because the ownership checks compare these inputs directly with the pad outputs.

The stimulus drives every input at the falling clock edge and holds pad_in steady for at least SYNC_STAGES cycles before a data read. Because of this, the value the bench expects from the synchronized pin is the level it applied. The random inputs always come from fully defined vectors, so the assumptions above hold throughout.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
   typedef enum logic [1:0] {
      REG_LATCH = 2'd0,
      REG_DIR   = 2'd1,
      REG_PULL  = 2'd2,
      REG_SLEW  = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_mux_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pull_q,
   output logic [WIDTH-1:0] slew_q
);
   localparam int NREGS = 4;

   logic [WIDTH-1:0] regs_q [NREGS];

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[r] <= '0;
         else if (wr_en && (addr == 2'(r)))
            regs_q[r] <= wdata;
      end
   end

   assign latch_q = regs_q[REG_LATCH];
   assign dir_q   = regs_q[REG_DIR];
   assign pull_q  = regs_q[REG_PULL];
   assign slew_q  = regs_q[REG_SLEW];

   // R2: a write lands in the selected register on the next cycle
   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DIR) |=> (dir_q == $past(wdata)));
   a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_LATCH) |=> (latch_q == $past(wdata)));
   a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> ($stable(dir_q) && $stable(latch_q) && $stable(pull_q) && $stable(slew_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage_q[0] <= '0;
      else
         stage_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= '0;
         else
            stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] slew_q,
   input  logic [WIDTH-1:0] periph_en,
   input  logic [WIDTH-1:0] periph_oe,
   input  logic [WIDTH-1:0] periph_out,
   input  logic [WIDTH-1:0] analog_en,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pull,
   output logic [WIDTH-1:0] pad_slew
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic oe_d;
      logic out_d;

      // priority: analog, then peripheral, then GPIO
      always_comb begin
         if (analog_en[i]) begin
            oe_d  = 1'b0;
            out_d = 1'b0;
         end else if (periph_en[i]) begin
            oe_d  = periph_oe[i];
            out_d = periph_out[i];
         end else begin
            oe_d  = dir_q[i];
            out_d = dir_q[i] & latch_q[i];
         end
      end

      assign pad_oe[i]   = oe_d;
      assign pad_out[i]  = out_d;
      assign pad_pull[i] = pull_q[i] & ~oe_d & ~analog_en[i];
      assign pad_slew[i] = slew_q[i] & ~analog_en[i];
   end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
   import gpio_mux_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] slew_q,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] analog_en,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] data_view;
   logic [WIDTH-1:0] rd_mux;

   for (genvar i = 0; i < WIDTH; i++) begin : g_view
      assign data_view[i] = analog_en[i] ? 1'b0
                          : (dir_q[i] ? latch_q[i] : pin_sync[i]);
   end

   always_comb begin
      unique case (gpio_reg_e'(addr))
         REG_LATCH: rd_mux = data_view;
         REG_DIR:   rd_mux = dir_q;
         REG_PULL:  rd_mux = pull_q;
         REG_SLEW:  rd_mux = slew_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_mux;
   end

   // R10: read data only moves on a read strobe
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en) |=> $stable(rdata));
   // R7: analog pins read as zero from the data register
   a_r7_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_LATCH) |=> (($past(analog_en) & rdata) == '0));
   // R5: output pins read back the latch
   a_r5_out_reads_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_LATCH) |=>
         ((($past(dir_q) & ~$past(analog_en)) & (rdata ^ $past(latch_q))) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_mux_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] periph_en,
   input  logic [WIDTH-1:0] periph_oe,
   input  logic [WIDTH-1:0] periph_out,
   input  logic [WIDTH-1:0] analog_en,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pull,
   output logic [WIDTH-1:0] pad_slew
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port_ctrl: WIDTH must be within 1..32");
   end

   logic [WIDTH-1:0] latch_q, dir_q, pull_q, slew_q, pin_sync;

   gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
   );

   gpio_pin_owner #(.WIDTH(WIDTH)) u_owner (
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q),
      .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
      .analog_en(analog_en),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_slew(pad_slew)
   );

   gpio_readback #(.WIDTH(WIDTH)) u_rb (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q),
      .pin_sync(pin_sync), .analog_en(analog_en), .rdata(bus_rdata)
   );

   // R7: analog pins never drive, pull or slew
   a_r7_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((analog_en & (pad_oe | pad_out | pad_pull | pad_slew)) == '0));
   // R8: pull-up never coexists with an active driver
   a_r8_pull_input_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pull & pad_oe) == '0));
   // R6: peripheral pins follow the peripheral
   a_r6_periph_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (((periph_en & ~analog_en) & ((pad_oe ^ periph_oe) | (pad_out ^ periph_out))) == '0));
   // R5: GPIO output pins drive the latch
   a_r5_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (((~periph_en & ~analog_en & dir_q) & (~pad_oe | (pad_out ^ latch_q))) == '0));
   // R4: a data write to GPIO input pins leaves them undriven
   a_r4_input_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_LATCH) |=>
         ((($past(~dir_q & ~periph_en & ~analog_en) & ~dir_q & ~periph_en & ~analog_en)
           & (pad_oe | pad_out)) == '0));
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] periph_en = '0, periph_oe = '0, periph_out = '0, analog_en = '0, pad_in = '0;
   logic [W-1:0] pad_out, pad_oe, pad_pull, pad_slew;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [W-1:0] m_latch = '0, m_dir = '0, m_pull = '0, m_slew = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
      .analog_en(analog_en), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_slew(pad_slew)
   );

   function automatic logic [W-1:0] exp_oe();
      return ~analog_en & ((periph_en & periph_oe) | (~periph_en & m_dir));
   endfunction
   function automatic logic [W-1:0] exp_out();
      return ~analog_en & ((periph_en & periph_out) | (~periph_en & m_dir & m_latch));
   endfunction
   function automatic logic [W-1:0] exp_pull();
      return m_pull & ~analog_en & ~exp_oe();
   endfunction
   function automatic logic [W-1:0] exp_slew();
      return m_slew & ~analog_en;
   endfunction
   function automatic logic [W-1:0] exp_data();
      return ~analog_en & ((m_dir & m_latch) | (~m_dir & pad_in));
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         2'd0: m_latch = d;
         2'd1: m_dir = d;
         2'd2: m_pull = d;
         default: m_slew = d;
      endcase
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic check_pads(input string tag);
      check({tag, " pad_oe"}, pad_oe, exp_oe());
      check({tag, " pad_out"}, pad_out, exp_out());
      check({tag, " pad_pull R8"}, pad_pull, exp_pull());
      check({tag, " pad_slew R9"}, pad_slew, exp_slew());
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, held;
      void'($urandom(32'd9137));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 pad_oe", pad_oe, '0);
      check("R1 pad_out", pad_out, '0);
      check("R1 pad_pull", pad_pull, '0);
      check("R1 pad_slew", pad_slew, '0);
      bus_read(2'd1, v); check("R1 dir reg", v, '0);
      bus_read(2'd2, v); check("R1 pull reg", v, '0);

      // R2: decode of each configuration register
      bus_write(2'd1, 8'h00);
      bus_write(2'd2, 8'hA5); bus_read(2'd2, v); check("R2 pull readback", v, 8'hA5);
      bus_write(2'd3, 8'h3C); bus_read(2'd3, v); check("R2 slew readback", v, 8'h3C);
      bus_read(2'd1, v); check("R2 dir readback", v, 8'h00);

      // R3: inputs read synchronized pad level
      pad_in = 8'h96; settle();
      bus_read(2'd0, v); check("R3 input read", v, 8'h96);
      check("R3 oe off", pad_oe, 8'h00);

      // R4: preload latch while input, then enable output
      bus_write(2'd0, 8'h5A);
      check("R4 no drive after write", pad_oe, 8'h00);
      check("R4 out quiet after write", pad_out, 8'h00);
      bus_write(2'd1, 8'hFF);
      check("R4 preloaded drive", pad_out, 8'h5A);
      // R5: outputs drive and read back latch
      check("R5 oe on", pad_oe, 8'hFF);
      bus_read(2'd0, v); check("R5 read latch", v, 8'h5A);

      // R6: peripheral owns some pins, read follows dir
      bus_write(2'd1, 8'h0F);
      periph_en = 8'hF0; periph_oe = 8'hC0; periph_out = 8'hA0; pad_in = 8'h33; settle();
      check_pads("R6");
      bus_read(2'd0, v); check("R6 read follows dir", v, exp_data());

      // R7: analog overrides peripheral and GPIO
      analog_en = 8'hC3; settle();
      check_pads("R7");
      bus_read(2'd0, v); check("R7 analog reads zero", v & analog_en, 8'h00);
      check("R7 other bits", v, exp_data());

      // R10: read data holds without strobe
      held = bus_rdata;
      pad_in = ~pad_in; bus_write(2'd0, ~m_latch); settle();
      check("R10 rdata hold", bus_rdata, held);

      // random phase
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         periph_en  = W'($urandom);
         periph_oe  = W'($urandom);
         periph_out = W'($urandom);
         analog_en  = W'($urandom) & W'($urandom);
         pad_in     = W'($urandom);
         if ($urandom_range(0, 1) == 1)
            bus_write(2'($urandom_range(0, 3)), W'($urandom));
         settle();
         check_pads("R5 R6 R7 random");
         bus_read(2'd0, v);
         check("R3 R5 R6 R7 random data read", v, exp_data());
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule